// File: doc/BRIEF.md
# Transmit Idle-Fill Sync Inserter

This block sits between a transmit FIFO and the load port of a serializer. On every character clock it either takes the next character from the FIFO or, when the FIFO has nothing to give, loads a fill symbol so that the line never stalls. The FIFO is read in first-word-fall-through style: the character on `fifo_data` is consumed in the same cycle that `fifo_rd` is high.

A mode input selects between two character widths. In narrow (10-bit) mode the fill symbol is the K28.5 comma. Successive fills alternate between its negative and positive running-disparity forms. This alternation is driven only by the inserter's own toggle, which no encoder state or preceding data character affects. In wide (12-bit) mode the fill symbol is a fixed bit pattern. A gap-free stream appears only when the FIFO is refilled at least as fast as it is drained.

Top module: `txfill_inserter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `tx_char` is 0 and `fill_flag` is 0.
- R2: `fifo_rd` is high exactly in those cycles where `rst_n` is high and `fifo_empty` is low.
- R3: When `fifo_empty` is low at a clock edge, `tx_char` after that edge holds the input character. In narrow mode (`wide_mode`=0) bits [9:0] of `fifo_data` are loaded and bits [11:10] are 0. In wide mode all 12 bits are loaded.
- R4: The first narrow-mode fill after reset is the negative-disparity K28.5 form 0011111010 (0x0FA, bit 9 first as written).
- R5: Consecutive narrow-mode fills alternate between 0x0FA and the positive-disparity form 1100000101 (0x305).
- R6: The disparity toggle keeps its state across data characters: after any run of data characters, the next narrow fill is the opposite form of the last narrow fill.
- R7: A wide-mode fill loads 0xC23, the low 12 bits of the pattern 0110000100011.
- R8: `fill_flag` is 1 after a clock edge exactly when a fill symbol was loaded at that edge, that is, when `fifo_empty` was high.
- R9: Wide-mode fills do not advance the narrow-mode disparity toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 0: 10-bit characters, 1: 12-bit characters |
| fifo_empty | input | 1 | Transmit FIFO has no character available |
| fifo_data | input | 12 | Head character of the transmit FIFO |
| fifo_rd | output | 1 | Pops the FIFO head this cycle |
| tx_char | output | 12 | Character loaded for the serializer |
| fill_flag | output | 1 | The loaded character is a fill symbol |

## Verification
The bench builds the block with its defaults: a 12-bit character port and a 10-bit narrow width. These values bring both modes within reach. They also cover the truncation of the 13-bit wide pattern to 12 bits and the zero-extension of narrow characters. Directed sequences cover fill alternation, toggle retention across data and across wide fills, and toggle restart on a second reset. A pseudo-random stretch then mixes empty flags, modes and data against the behavioural model.

// File: rtl/txfill_pkg.sv
// Shared constants for the transmit idle-fill inserter.
// Assumes the wide character is at most 13 bits (the length of the wide pattern).
package txfill_pkg;
    localparam int NARROW_BITS = 10;
    localparam logic [NARROW_BITS-1:0] COMMA_RD_NEG = 10'b0011111010;
    localparam logic [NARROW_BITS-1:0] COMMA_RD_POS = 10'b1100000101;
    localparam logic [12:0]            WIDE_PATTERN = 13'b0110000100011;
endpackage

// File: rtl/txfill_symgen.sv
// Fill symbol generator: holds the K28.5 disparity toggle and presents the
// fill symbol for the current mode. The toggle advances only when a narrow
// fill is actually loaded. Assumes CHAR_W >= NARROW_W and CHAR_W <= 13.
module txfill_symgen
    import txfill_pkg::*;
#(
    parameter int CHAR_W   = 12,
    parameter int NARROW_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_fill,
    input  logic              wide_mode,
    output logic [CHAR_W-1:0] fill_sym
);
    localparam logic [CHAR_W-1:0] FILL_WIDE = WIDE_PATTERN[CHAR_W-1:0];

    logic                rd_pos;
    logic [NARROW_W-1:0] comma;
    logic [CHAR_W-1:0]   comma_ext;

    // Disparity toggle: flips on each narrow fill, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_pos <= 1'b0;
        else if (load_fill && !wide_mode)
            rd_pos <= ~rd_pos;
    end

    // Pick the comma form for the current toggle state.
    always_comb begin
        comma = rd_pos ? COMMA_RD_POS[NARROW_W-1:0] : COMMA_RD_NEG[NARROW_W-1:0];
    end

    generate
        if (CHAR_W > NARROW_W) begin : g_pad
            assign comma_ext = {{(CHAR_W-NARROW_W){1'b0}}, comma};
        end else begin : g_same
            assign comma_ext = comma;
        end
    endgenerate

    // Mode selects between the comma and the fixed wide pattern.
    always_comb begin
        fill_sym = wide_mode ? FILL_WIDE : comma_ext;
    end
endmodule

// File: rtl/txfill_outreg.sv
// Output stage: chooses FIFO data or the fill symbol and registers the
// character and its fill flag. Narrow data is masked to NARROW_W bits.
module txfill_outreg #(
    parameter int CHAR_W   = 12,
    parameter int NARROW_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic              wide_mode,
    input  logic [CHAR_W-1:0] fifo_data,
    input  logic [CHAR_W-1:0] fill_sym,
    output logic [CHAR_W-1:0] tx_char,
    output logic              fill_flag
);
    localparam logic [CHAR_W-1:0] NARROW_MASK = CHAR_W'((1 << NARROW_W) - 1);

    logic [CHAR_W-1:0] data_sel;

    // Trim data to the active character width.
    always_comb begin
        data_sel = wide_mode ? fifo_data : (fifo_data & NARROW_MASK);
    end

    // Load either the fill symbol or the trimmed data each character period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_char   <= '0;
            fill_flag <= 1'b0;
        end else if (fifo_empty) begin
            tx_char   <= fill_sym;
            fill_flag <= 1'b1;
        end else begin
            tx_char   <= data_sel;
            fill_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/txfill_inserter.sv
// Transmit idle-fill inserter top. Pops the FIFO whenever it holds a
// character (first-word-fall-through), otherwise loads a sync fill.
// Assumes one character per clock.
module txfill_inserter #(
    parameter int CHAR_W   = 12,
    parameter int NARROW_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_data,
    output logic              fifo_rd,
    output logic [CHAR_W-1:0] tx_char,
    output logic              fill_flag
);
    logic [CHAR_W-1:0] fill_sym;

    // Read strobe: pop only out of reset and when a character waits.
    always_comb begin
        fifo_rd = rst_n && !fifo_empty;
    end

    txfill_symgen #(.CHAR_W(CHAR_W), .NARROW_W(NARROW_W)) u_symgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_fill (fifo_empty),
        .wide_mode (wide_mode),
        .fill_sym  (fill_sym)
    );

    txfill_outreg #(.CHAR_W(CHAR_W), .NARROW_W(NARROW_W)) u_outreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .wide_mode  (wide_mode),
        .fifo_data  (fifo_data),
        .fill_sym   (fill_sym),
        .tx_char    (tx_char),
        .fill_flag  (fill_flag)
    );
endmodule

// File: rtl/txfill_checker.sv
// Property checker for the idle-fill inserter, bound to the top.
module txfill_checker #(
    parameter int CHAR_W   = 12,
    parameter int NARROW_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wide_mode,
    input logic              fifo_empty,
    input logic [CHAR_W-1:0] fifo_data,
    input logic              fifo_rd,
    input logic [CHAR_W-1:0] tx_char,
    input logic              fill_flag
);
    logic past_ok;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2
    a_r2_rd_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    // R8
    a_r8_flag_tracks_empty: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (fill_flag == $past(fifo_empty)));

    // R3
    a_r3_wide_data_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(fifo_empty) && $past(wide_mode)) |-> (tx_char == $past(fifo_data)));

    // R4
    a_r4_narrow_fill_is_comma: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && fill_flag && !$past(wide_mode)) |->
        (tx_char == CHAR_W'(10'h0FA) || tx_char == CHAR_W'(10'h305)));

    // R5
    a_r5_fills_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(past_ok) && fill_flag && $past(fill_flag)
         && !$past(wide_mode) && !$past(wide_mode, 2)) |-> (tx_char != $past(tx_char)));

    // R7
    a_r7_wide_fill_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && fill_flag && $past(wide_mode)) |-> (tx_char == CHAR_W'(12'hC23)));
endmodule

bind txfill_inserter txfill_checker #(.CHAR_W(CHAR_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/txfill_inserter_bench.sv
module txfill_inserter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic        fifo_empty = 1'b1;
    logic [11:0] fifo_data = '0;
    logic        fifo_rd;
    logic [11:0] tx_char;
    logic        fill_flag;

    int total = 0;
    int bad = 0;
    int pol = 0;  // reference toggle: 0 = next narrow fill is RD-

    always #2 clk = ~clk;

    txfill_inserter u_txfill_inserter (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_rd(fifo_rd), .tx_char(tx_char), .fill_flag(fill_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One character period: drive at negedge, check strobe, model, compare after edge.
    task automatic step(input bit emp, input bit wide, input logic [11:0] d, input string tag);
        int exp_c;
        @(negedge clk);
        fifo_empty = emp; wide_mode = wide; fifo_data = d;
        #1;
        check("R2 fifo_rd", int'(fifo_rd), int'(!emp));
        if (emp) begin
            exp_c = wide ? 12'hC23 : (pol != 0 ? 12'h305 : 12'h0FA);
            if (!wide) pol = 1 - pol;
        end else begin
            exp_c = wide ? int'(d) : int'(d & 12'h3FF);
        end
        @(posedge clk);
        #1;
        check({tag, " tx_char"}, int'(tx_char), exp_c);
        check("R8 fill_flag", int'(fill_flag), int'(emp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fifo_empty = 1'b0; fifo_data = 12'h155;
        #1;
        check("R2 fifo_rd in reset", int'(fifo_rd), 0);
        @(posedge clk); #1;
        check("R1 tx_char", int'(tx_char), 0);
        check("R1 fill_flag", int'(fill_flag), 0);
        @(negedge clk);
        rst_n = 1'b1;
        pol = 0;
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();
        step(0, 0, 12'hABC, "R3 narrow data");
        step(1, 0, 12'h000, "R4 first fill");
        step(1, 0, 12'h000, "R5 second fill");
        step(0, 0, 12'h123, "R3 narrow data");
        step(0, 0, 12'hFFF, "R3 narrow mask");
        step(1, 0, 12'h000, "R6 fill after data");
        step(1, 0, 12'h000, "R5 alternate");
        step(1, 0, 12'h000, "R5 alternate");
        step(1, 1, 12'h000, "R7 wide fill");
        step(1, 1, 12'h000, "R7 wide fill");
        step(0, 1, 12'hABC, "R3 wide data");
        step(1, 0, 12'h000, "R9 narrow after wide fills");
        do_reset();
        step(1, 0, 12'h000, "R4 first fill after reset");
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[5], lfsr[3] & lfsr[7], lfsr[15:4], "R3 mixed");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule